// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Channel

This block is one receive channel of a DMA engine. Software places a circular ring of 64-bit descriptors in memory. Each descriptor is a 32-bit control word followed by a 32-bit buffer pointer. The channel fetches the descriptor at its current index. It waits until software has handed that entry over. It then moves bytes from an incoming byte stream into the buffer and writes the control word back. The written-back word gives the stored length and says whether this buffer opens or closes a packet.

A packet that does not fit in one buffer runs on into the following descriptors. Only the first of those carries the start flag, and only the last carries the end flag. Each returned descriptor produces a one-cycle completion pulse. Ring base and ring length are inputs that can be changed while the channel reset is asserted. The channel reset sends the walk back to entry 0.

The memory port is one 32-bit word wide, with byte enables. A read returns data on the cycle after the request.

Top module: `rx_ring_dma`

## Requirements
- R1: Descriptor `i` sits at `ring_base + 8*i`. Its control word is at offset 0 and its buffer address at offset 4. Control word fields: bit 31 owner (1 = channel may use it), bit 30 complete, bit 29 start-of-packet, bit 28 end-of-packet, bits 25:23 receive byte offset, bits 15:0 length (buffer capacity on fetch, bytes stored on write-back). A read request returns its word on `mem_rdata` in the following cycle.
- R2: The channel fills a descriptor only when its owner bit reads 1. Otherwise it re-reads the same entry, keeps `s_ready` low and takes no bytes.
- R3: Byte k taken into a descriptor is stored at byte address `buffer + offset + k`, for k below the fetched length. Bytes are written little-endian: address a goes to lane a mod 4, which is data bits 8*(a mod 4)+7 down to 8*(a mod 4). Only the lanes that carry new bytes are enabled.
- R4: A descriptor is returned when its capacity is used up, or when a byte flagged `s_last` is stored. The returned control word has owner 0 and complete 1. It keeps the fetched offset, holds the stored byte count in bits 15:0, and has bits 27:26 and 22:16 zero.
- R5: A packet spread over several descriptors gets the start flag only in its first descriptor and the end flag only in the descriptor holding its last byte.
- R6: `desc_done` is high for exactly one cycle, in the cycle after each control-word write-back.
- R7: After each write-back the index advances by one. It wraps to 0 once it reaches `ring_len`, which must be 1 to `MAX_DESC`, so entries at or beyond `ring_len` are never touched.
- R8: `rst` or `chan_rst` returns the index to entry 0, drops any partly filled descriptor, and makes the next stored byte a packet start. In the cycle after either reset, `s_ready`, `mem_req` and `desc_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; sampled when idle and after each write-back |
| chan_rst | input | 1 | Synchronous channel reset (index to 0, abort) |
| ring_base | input | 32 | Byte address of descriptor 0 (8-byte aligned) |
| ring_len | input | 7 | Number of descriptors in the ring, 1 to MAX_DESC |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Byte is the last of its packet |
| s_ready | output | 1 | Channel accepts the stream byte this cycle |
| desc_done | output | 1 | One-cycle pulse per returned descriptor |

## Verification
The bound checker watches the following on every cycle:
- the completion pulse always follows a full-width write with owner clear and complete set, and it never lasts two cycles;
- every memory write enables at least one lane;
- no byte is taken while the memory port is busy;
- every read stays inside the configured ring window;
- the channel is quiet right after a channel reset.

Only the bench scenarios can show the rest:
- the correct byte landing at the correct offset;
- the split of start and end flags across spanning descriptors;
- re-polling of an entry software has not handed over;
- the wrap back to entry 0;
- a fresh packet start after an abort.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int CTL_BIT_OWN  = 31;
    localparam int CTL_BIT_CMPL = 30;
    localparam int CTL_BIT_SOP  = 29;
    localparam int CTL_BIT_EOP  = 28;
    localparam int OFS_LSB      = 23;
    localparam int OFS_W        = 3;
    localparam int LEN_W        = 16;
    localparam int POS_W        = LEN_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CTL,
        ST_WAIT_CTL,
        ST_RD_BUF,
        ST_WAIT_BUF,
        ST_FILL,
        ST_FLUSH,
        ST_WB_CTL
    } chan_state_e;

    typedef struct packed {
        logic             own;
        logic             cmpl;
        logic             sop;
        logic             eop;
        logic [OFS_W-1:0] ofs;
        logic [LEN_W-1:0] len;
    } desc_ctl_t;

    function automatic desc_ctl_t ctl_unpack(input logic [31:0] w);
        desc_ctl_t c;
        c.own  = w[CTL_BIT_OWN];
        c.cmpl = w[CTL_BIT_CMPL];
        c.sop  = w[CTL_BIT_SOP];
        c.eop  = w[CTL_BIT_EOP];
        c.ofs  = w[OFS_LSB +: OFS_W];
        c.len  = w[LEN_W-1:0];
        return c;
    endfunction

    function automatic logic [31:0] ctl_pack(input desc_ctl_t c);
        logic [31:0] w;
        w                     = '0;
        w[CTL_BIT_OWN]        = c.own;
        w[CTL_BIT_CMPL]       = c.cmpl;
        w[CTL_BIT_SOP]        = c.sop;
        w[CTL_BIT_EOP]        = c.eop;
        w[OFS_LSB +: OFS_W]   = c.ofs;
        w[LEN_W-1:0]          = c.len;
        return w;
    endfunction

endpackage

// File: rtl/rxdma_ring_idx.sv
module rxdma_ring_idx #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [IDX_W:0]   ring_len,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W:0] nxt;

    assign nxt = {1'b0, idx} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (adv) begin
            idx <= (nxt >= ring_len) ? '0 : nxt[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/rxdma_lane_pack.sv
module rxdma_lane_pack (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        load,
    input  logic [1:0]  lane,
    input  logic [7:0]  din,
    output logic [31:0] word,
    output logic [3:0]  be
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            word <= '0;
            be   <= '0;
        end else if (load) begin
            word[lane*8 +: 8] <= din;
            be[lane]          <= 1'b1;
        end
    end
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
    import rxdma_pkg::*;
#(
    parameter int MAX_DESC = 64,
    localparam int IDX_W   = $clog2(MAX_DESC)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         chan_en,
    input  logic         chan_rst,
    input  logic [31:0]  ring_base,
    input  logic [IDX_W:0] ring_len,
    output logic         mem_req,
    output logic         mem_we,
    output logic [31:0]  mem_addr,
    output logic [3:0]   mem_be,
    output logic [31:0]  mem_wdata,
    input  logic [31:0]  mem_rdata,
    input  logic         s_valid,
    input  logic [7:0]   s_data,
    input  logic         s_last,
    output logic         s_ready,
    output logic         desc_done
);
    chan_state_e      state;
    desc_ctl_t        cur_ctl;
    desc_ctl_t        rd_ctl;
    desc_ctl_t        wb_ctl;
    logic [31:0]      buf_addr;
    logic [POS_W-1:0] pos;
    logic [LEN_W-1:0] cnt;
    logic [POS_W-3:0] wr_word;
    logic             fin;
    logic             eop_seen;
    logic             pkt_start;
    logic [IDX_W-1:0] idx;
    logic [31:0]      slot;
    logic [31:0]      pk_word;
    logic [3:0]       pk_be;
    logic             take;
    logic             cap_hit;
    logic             end_now;
    logic             word_full;
    logic             adv;
    logic             pk_clr;

    rxdma_ring_idx #(.IDX_W(IDX_W)) u_idx (
        .clk      (clk),
        .rst      (rst),
        .clr      (chan_rst),
        .adv      (adv),
        .ring_len (ring_len),
        .idx      (idx)
    );

    rxdma_lane_pack u_pack (
        .clk  (clk),
        .rst  (rst || chan_rst),
        .clr  (pk_clr),
        .load (take),
        .lane (pos[1:0]),
        .din  (s_data),
        .word (pk_word),
        .be   (pk_be)
    );

    assign slot      = ring_base + 32'({idx, 3'b000});
    assign rd_ctl    = ctl_unpack(mem_rdata);
    assign s_ready   = (state == ST_FILL);
    assign take      = s_ready && s_valid;
    assign cap_hit   = ({1'b0, cnt} + 17'd1) == {1'b0, cur_ctl.len};
    assign end_now   = s_last || cap_hit;
    assign word_full = (pos[1:0] == 2'd3);
    assign adv       = (state == ST_WB_CTL);
    assign pk_clr    = (state == ST_FLUSH) || (state == ST_WAIT_BUF);

    always_comb begin
        wb_ctl      = '0;
        wb_ctl.own  = 1'b0;
        wb_ctl.cmpl = 1'b1;
        wb_ctl.sop  = pkt_start;
        wb_ctl.eop  = eop_seen;
        wb_ctl.ofs  = cur_ctl.ofs;
        wb_ctl.len  = cnt;
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = slot;
        mem_be    = 4'h0;
        mem_wdata = '0;
        unique case (state)
            ST_RD_CTL: mem_req = 1'b1;
            ST_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = slot + 32'd4;
            end
            ST_FLUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_addr + 32'({wr_word, 2'b00});
                mem_be    = pk_be;
                mem_wdata = pk_word;
            end
            ST_WB_CTL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = 4'hF;
                mem_wdata = ctl_pack(wb_ctl);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || chan_rst) begin
            state     <= ST_IDLE;
            cur_ctl   <= '0;
            buf_addr  <= '0;
            pos       <= '0;
            cnt       <= '0;
            wr_word   <= '0;
            fin       <= 1'b0;
            eop_seen  <= 1'b0;
            pkt_start <= 1'b1;
            desc_done <= 1'b0;
        end else begin
            desc_done <= 1'b0;
            unique case (state)
                ST_IDLE:     if (chan_en) state <= ST_RD_CTL;
                ST_RD_CTL:   state <= ST_WAIT_CTL;
                ST_WAIT_CTL: begin
                    if (rd_ctl.own) begin
                        cur_ctl <= rd_ctl;
                        state   <= ST_RD_BUF;
                    end else begin
                        state   <= ST_RD_CTL;
                    end
                end
                ST_RD_BUF:   state <= ST_WAIT_BUF;
                ST_WAIT_BUF: begin
                    buf_addr <= mem_rdata;
                    pos      <= POS_W'(cur_ctl.ofs);
                    cnt      <= '0;
                    fin      <= 1'b0;
                    eop_seen <= 1'b0;
                    state    <= (cur_ctl.len == '0) ? ST_WB_CTL : ST_FILL;
                end
                ST_FILL: begin
                    if (take) begin
                        wr_word  <= pos[POS_W-1:2];
                        pos      <= pos + 1'b1;
                        cnt      <= cnt + 1'b1;
                        fin      <= end_now;
                        eop_seen <= s_last;
                        if (word_full || end_now) state <= ST_FLUSH;
                    end
                end
                ST_FLUSH:    state <= fin ? ST_WB_CTL : ST_FILL;
                ST_WB_CTL: begin
                    desc_done <= 1'b1;
                    if (cnt != '0) pkt_start <= eop_seen;
                    state <= chan_en ? ST_RD_CTL : ST_IDLE;
                end
                default:     state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk #(
    parameter int MAX_DESC = 64,
    localparam int IDX_W   = $clog2(MAX_DESC)
) (
    input logic           clk,
    input logic           rst,
    input logic           chan_rst,
    input logic [31:0]    ring_base,
    input logic [IDX_W:0] ring_len,
    input logic           mem_req,
    input logic           mem_we,
    input logic [31:0]    mem_addr,
    input logic [3:0]     mem_be,
    input logic [31:0]    mem_wdata,
    input logic           s_ready,
    input logic           desc_done
);
    logic [31:0] ring_span;
    assign ring_span = 32'(ring_len) << 3;

    assert_wb_format_R4: assert property (@(posedge clk) disable iff (rst)
        desc_done |-> $past(mem_req && mem_we && mem_be == 4'hF &&
                            !mem_wdata[31] && mem_wdata[30]));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        desc_done |=> !desc_done);

    assert_no_take_while_busy_R2: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> !mem_req);

    assert_write_lanes_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_be != 4'h0));

    assert_read_in_ring_R7: assert property (@(posedge clk) disable iff (rst || chan_rst)
        (mem_req && !mem_we) |-> ((mem_addr - ring_base) < ring_span));

    assert_chan_reset_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        chan_rst |=> (!s_ready && !mem_req && !desc_done));
endmodule

bind rx_ring_dma rx_ring_dma_chk #(.MAX_DESC(MAX_DESC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .chan_rst  (chan_rst),
    .ring_base (ring_base),
    .ring_len  (ring_len),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .s_ready   (s_ready),
    .desc_done (desc_done)
);

// File: tb/tb_rx_ring_dma.sv
`timescale 1ns/1ps
module tb_rx_ring_dma;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chan_en = 1'b0;
    logic        chan_rst = 1'b0;
    logic [31:0] ring_base = 32'h100;
    logic [6:0]  ring_len = 7'd8;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_last = 1'b0;
    logic        s_ready, desc_done;

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    logic [31:0] ram [0:1023];

    always #2 clk = ~clk;

    rx_ring_dma dut (
        .clk(clk), .rst(rst), .chan_en(chan_en), .chan_rst(chan_rst),
        .ring_base(ring_base), .ring_len(ring_len),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_ready(s_ready), .desc_done(desc_done)
    );

    // memory model: one-cycle read latency, byte-enabled writes
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) ram[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            end else begin
                mem_rdata <= ram[mem_addr[11:2]];
            end
        end
    end

    always @(negedge clk) if (desc_done) done_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input int seed, input int i);
        return 8'(seed * 37 + i * 11 + 5);
    endfunction

    function automatic logic [7:0] rd_byte(input int a);
        return ram[a >> 2][(a % 4) * 8 +: 8];
    endfunction

    function automatic logic [31:0] ctl_word(input bit own, input bit c, input bit sop,
                                            input bit eop, input int off, input int len);
        return {own, c, sop, eop, 2'b00, 3'(off), 7'b0, 16'(len)};
    endfunction

    function automatic int buf_of(input int j);
        return 32'h800 + j * 32'h80;
    endfunction

    task automatic prog_desc(input int j, input bit own, input int cap, input int off);
        ram[(32'h100 + j * 8) >> 2]     = ctl_word(own, 1'b0, 1'b0, 1'b0, off, cap);
        ram[(32'h100 + j * 8 + 4) >> 2] = buf_of(j);
    endtask

    function automatic logic [31:0] rd_ctl(input int j);
        return ram[(32'h100 + j * 8) >> 2];
    endfunction

    task automatic send_bytes(input int len, input int seed, input bit with_last);
        for (int i = 0; i < len; i++) begin
            s_valid = 1'b1;
            s_data  = pbyte(seed, i);
            s_last  = with_last && (i == len - 1);
            while (!s_ready) @(negedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic wait_done(input int target);
        int g = 0;
        while (done_cnt < target && g < 3000) begin
            @(negedge clk);
            g++;
        end
        repeat (4) @(negedge clk);
    endtask

    // vectors: packet length, descriptor capacity, receive offset
    localparam int NV = 8;
    localparam int VEC [NV][3] = '{
        '{5, 16, 0}, '{16, 16, 0}, '{20, 8, 1}, '{3, 4, 3},
        '{17, 5, 7}, '{1, 1, 0},  '{9, 3, 2},  '{12, 64, 5}
    };

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int w = 0; w < 1024; w++) ram[w] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset s_ready", 32'(s_ready), 0);
        chk("R8 reset mem_req", 32'(mem_req), 0);
        chk("R8 reset desc_done", 32'(desc_done), 0);
        chan_en = 1'b1;

        // table walk: R1 R3 R4 R5 R6 R2
        for (int v = 0; v < NV; v++) begin
            int len = VEC[v][0];
            int cap = VEC[v][1];
            int off = VEC[v][2];
            int n = (len + cap - 1) / cap;
            int base;
            chan_rst = 1'b1;
            ring_len = 7'd8;
            for (int j = 0; j < 8; j++) prog_desc(j, 1'b1, cap, off);
            @(negedge clk);
            chan_rst = 1'b0;
            base = done_cnt;
            send_bytes(len, v + 1, 1'b1);
            wait_done(base + n);
            chk("R6 pulses per packet", 32'(done_cnt - base), 32'(n));
            for (int j = 0; j < n; j++) begin
                int part = (len - j * cap < cap) ? len - j * cap : cap;
                int mism = 0;
                chk("R4 R5 returned ctl", rd_ctl(j),
                    ctl_word(1'b0, 1'b1, j == 0, j == n - 1, off, part));
                for (int k = 0; k < part; k++)
                    if (rd_byte(buf_of(j) + off + k) !== pbyte(v + 1, j * cap + k)) mism++;
                chk("R3 R1 data placement", 32'(mism), 0);
            end
            if (n < 8)
                chk("R2 next entry untouched", rd_ctl(n), ctl_word(1'b1, 1'b0, 1'b0, 1'b0, off, cap));
        end

        // owner bit clear: channel stalls
        begin
            int base;
            int seen = 0;
            chan_rst = 1'b1;
            ring_len = 7'd4;
            for (int j = 0; j < 4; j++) prog_desc(j, 1'b0, 8, 0);
            @(negedge clk);
            chan_rst = 1'b0;
            base = done_cnt;
            s_valid = 1'b1;
            s_data = 8'hAA;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (s_ready) seen++;
            end
            chk("R2 no ready while not owned", 32'(seen), 0);
            chk("R2 no return while not owned", 32'(done_cnt - base), 0);
            prog_desc(0, 1'b1, 8, 0);
            send_bytes(4, 20, 1'b1);
            wait_done(base + 1);
            chk("R2 taken after handover", rd_ctl(0), ctl_word(1'b0, 1'b1, 1'b1, 1'b1, 0, 4));
        end

        // wrap at ring length
        begin
            int base;
            int mism = 0;
            chan_rst = 1'b1;
            ring_len = 7'd2;
            for (int j = 0; j < 3; j++) prog_desc(j, 1'b1, 8, 0);
            @(negedge clk);
            chan_rst = 1'b0;
            base = done_cnt;
            send_bytes(3, 30, 1'b1);
            wait_done(base + 1);
            send_bytes(4, 31, 1'b1);
            wait_done(base + 2);
            prog_desc(0, 1'b1, 8, 0);
            send_bytes(6, 32, 1'b1);
            wait_done(base + 3);
            chk("R7 wrapped into entry 0", rd_ctl(0), ctl_word(1'b0, 1'b1, 1'b1, 1'b1, 0, 6));
            chk("R7 entry 1 used once", rd_ctl(1), ctl_word(1'b0, 1'b1, 1'b1, 1'b1, 0, 4));
            chk("R7 entry past ring untouched", rd_ctl(2), ctl_word(1'b1, 1'b0, 1'b0, 1'b0, 0, 8));
            for (int k = 0; k < 6; k++)
                if (rd_byte(buf_of(0) + k) !== pbyte(32, k)) mism++;
            chk("R7 wrapped data", 32'(mism), 0);
        end

        // channel reset mid-packet
        begin
            int base;
            chan_rst = 1'b1;
            ring_len = 7'd4;
            for (int j = 0; j < 4; j++) prog_desc(j, 1'b1, 4, 0);
            @(negedge clk);
            chan_rst = 1'b0;
            base = done_cnt;
            send_bytes(5, 40, 1'b0);
            wait_done(base + 1);
            chk("R5 first part open", rd_ctl(0), ctl_word(1'b0, 1'b1, 1'b1, 1'b0, 0, 4));
            chan_rst = 1'b1;
            for (int j = 0; j < 4; j++) prog_desc(j, 1'b1, 4, 0);
            @(negedge clk);
            chan_rst = 1'b0;
            chk("R8 quiet after channel reset", 32'({s_ready, mem_req, desc_done}), 0);
            base = done_cnt;
            send_bytes(3, 41, 1'b1);
            wait_done(base + 1);
            chk("R8 restart at entry 0 with start", rd_ctl(0), ctl_word(1'b0, 1'b1, 1'b1, 1'b1, 0, 3));
            chk("R8 entry 1 not used", rd_ctl(1), ctl_word(1'b1, 1'b0, 1'b0, 1'b0, 0, 4));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule